// File: doc/BRIEF.md
# Prefetching Microcode Sequencer

This block steps through microcode for a small processor core. It reads the control store one cycle ahead of the datapath. The block holds a step index and a micro-instruction register. On every clock edge the register takes the word that the control store gives at {opcode, index}. That word therefore already drives the datapath when the next cycle begins, so the control-store read time no longer adds to the datapath timing path.

The first execution step after an opcode fetch is almost always the same: read the operand at PC, then increment PC. An all-zero control word encodes that step. Clearing the register when an opcode is fetched supplies the step, so the stored microcode for each opcode begins at its second cycle, at index 0. The block also accepts three requests:
- A force-fetch request makes the next cycle an opcode fetch. This ends the instruction early.
- A stall request holds the index.
- An injected word replaces the control-store output for one cycle. This inserts an extra step.

The control store is a computed table inside the block.

Top module: `ucode_prefetch_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `ctrl` is 16'h0003 and the index (`rom_addr[3:0]`) is 0. The block therefore starts in an opcode-fetch cycle.
- R2: `rom_addr` is `{opcode, index}`, with the opcode in bits 11:4 and the index in bits 3:0. It follows a change of `opcode` within the same cycle.
- R3: The control store word at opcode `op` and index `q` is as follows. If `q >= op[1:0]`, the word is `{op, 8'h03}`. Otherwise it is `{op, q[2:0], q[0], ~q[0], 3'b000}`. Control bits: bit 0 = IR load, bit 1 = END, bit 2 = PC increment, bit 3 = address-low select, bit 4 = address-high select. Bits 15:5 are free datapath controls.
- R4: Suppose a cycle has `op_fetch` high or `ctrl[0]` (IR load) set. Then the next cycle has `ctrl` = 0 (the default operand-fetch step) and index 0.
- R5: In any other cycle with no stall and no injection, the next cycle's `ctrl` equals the control store word at this cycle's `rom_addr`, and the index increases by one.
- R6: After a cycle with `ctrl[1]` (END) set, the index is 0.
- R7: A cycle with `force_fetch` high makes the next cycle show `ctrl` = 16'h0003 (register cleared, IR load and END forced on) with index 0. The cycle after that is then a cleared default step.
- R8: While `stall` is high and the cycle is not an opcode fetch, the index keeps its value. The control store word at that index is therefore loaded again on the following edge.
- R9: A cycle with `inj_valid` high that is not an opcode fetch makes the next cycle's `ctrl` equal `inj_word`. Normal sequencing from the index resumes in the cycle after that.
- R10: A clear takes priority over an injection or a stall. With `op_fetch` or `force_fetch` high, `inj_valid` and `stall` have no effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_fetch | input | 1 | This cycle is an opcode fetch |
| force_fetch | input | 1 | Make the next cycle an opcode fetch |
| stall | input | 1 | Hold the step index this cycle |
| inj_valid | input | 1 | Load `inj_word` in place of the store output |
| inj_word | input | 16 | Word to insert |
| opcode | input | 8 | Current instruction opcode |
| ctrl | output | 16 | Control word for the current cycle |
| rom_addr | output | 12 | Control store address {opcode, index} |

## Verification
Every registered result appears exactly one clock edge after the inputs that cause it: the loaded control word, the cleared word, the forced fetch bits and the new index all follow this rule. Only `rom_addr` responds within the same cycle. The bench changes inputs one time unit after a rising edge and reads `ctrl` and the index one time unit after the following edge. Each expectation therefore covers exactly one register stage. The address check reads `rom_addr` after a short settle inside the same cycle.

// File: rtl/ucode_prefetch_seq.sv
module ucode_prefetch_seq #(
  parameter int OPW = 8,
  parameter int QW  = 4,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_fetch,
  input  logic              force_fetch,
  input  logic              stall,
  input  logic              inj_valid,
  input  logic [CW-1:0]     inj_word,
  input  logic [OPW-1:0]    opcode,
  output logic [CW-1:0]     ctrl,
  output logic [OPW+QW-1:0] rom_addr
);
  localparam int AW = OPW + QW;
  localparam logic [CW-1:0] FETCH_BITS = CW'(3);

  logic [QW-1:0] q;
  logic [CW-1:0] mir;
  logic          fetchop_q;
  logic          clr;
  logic          q_zero;
  logic [CW-1:0] store_out;

  function automatic logic [CW-1:0] store_word(input logic [AW-1:0] a);
    logic [OPW-1:0] op;
    logic [QW-1:0]  qi;
    logic [7:0]     lo;
    logic [CW-1:0]  w;
    op = a[AW-1:QW];
    qi = a[QW-1:0];
    case (op[1:0])
      2'd0:    lo = 8'h03;
      2'd1:    lo = (qi >= QW'(1)) ? 8'h03 : {qi[2:0], qi[0], ~qi[0], 3'b000};
      2'd2:    lo = (qi >= QW'(2)) ? 8'h03 : {qi[2:0], qi[0], ~qi[0], 3'b000};
      default: lo = (qi >= QW'(3)) ? 8'h03 : {qi[2:0], qi[0], ~qi[0], 3'b000};
    endcase
    w = '0;
    w[CW-1 -: OPW] = op;
    w[7:0] = lo;
    return w;
  endfunction

  assign rom_addr  = {opcode, q};
  assign store_out = store_word(rom_addr);
  assign ctrl      = mir | (fetchop_q ? FETCH_BITS : '0);
  assign clr       = op_fetch | force_fetch | ctrl[0];
  assign q_zero    = clr | ctrl[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q         <= '0;
      mir       <= '0;
      fetchop_q <= 1'b1;
    end else begin
      fetchop_q <= force_fetch;
      if (clr)            mir <= '0;
      else if (inj_valid) mir <= inj_word;
      else                mir <= store_out;
      if (q_zero)         q <= '0;
      else if (!stall)    q <= q + QW'(1);
    end
  end
endmodule

// File: rtl/ucode_prefetch_seq_chk.sv
module ucode_prefetch_seq_chk #(
  parameter int OPW = 8,
  parameter int QW  = 4,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_fetch,
  input logic              force_fetch,
  input logic              stall,
  input logic              inj_valid,
  input logic [CW-1:0]     inj_word,
  input logic [OPW-1:0]    opcode,
  input logic [CW-1:0]     ctrl,
  input logic [OPW+QW-1:0] rom_addr
);
  logic [QW-1:0] qv;
  logic          fetch_cyc;
  assign qv        = rom_addr[QW-1:0];
  assign fetch_cyc = op_fetch | force_fetch | ctrl[0];

  p_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_addr[OPW+QW-1:QW] == opcode);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_fetch || ctrl[0]) && !force_fetch) |=> (ctrl == '0 && qv == '0));

  p_end_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[1] |=> qv == '0);

  p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    force_fetch |=> (ctrl == CW'(3) && qv == '0));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !fetch_cyc && !ctrl[1]) |=> qv == $past(qv));

  p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !fetch_cyc && !ctrl[1]) |=> qv == QW'($past(qv) + QW'(1)));

  p_inject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && !fetch_cyc) |=> ctrl == $past(inj_word));
endmodule

bind ucode_prefetch_seq ucode_prefetch_seq_chk #(.OPW(OPW), .QW(QW), .CW(CW)) u_chk (.*);

// File: tb/tb_ucode_prefetch_seq.sv
module tb_ucode_prefetch_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_fetch, force_fetch, stall, inj_valid;
  logic [15:0] inj_word;
  logic [7:0]  opcode;
  logic [15:0] ctrl;
  logic [11:0] rom_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  ucode_prefetch_seq dut (
    .clk(clk), .rst_n(rst_n), .op_fetch(op_fetch), .force_fetch(force_fetch),
    .stall(stall), .inj_valid(inj_valid), .inj_word(inj_word), .opcode(opcode),
    .ctrl(ctrl), .rom_addr(rom_addr)
  );

  always #2 clk = ~clk;

  function automatic logic [15:0] exp_word(input logic [7:0] op, input logic [3:0] q);
    if (q >= {2'b00, op[1:0]}) return {op, 8'h03};
    return {op, q[2:0], q[0], ~q[0], 3'b000};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic go_idle(input logic [7:0] op);
    opcode = op; op_fetch = 1'b1;
    tick();
    op_fetch = 1'b0;
    chk("R4 ctrl", ctrl, 16'h0000);
    chk("R4 q", {12'h0, rom_addr[3:0]}, 16'h0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(); tick();
    chk("R1 ctrl in reset", ctrl, 16'h0003);
    chk("R1 q in reset", {12'h0, rom_addr[3:0]}, 16'h0);
    rst_n = 1'b1;
    chk("R1 first cycle ctrl", ctrl, 16'h0003);
    opcode = 8'h42;
    tick();
    chk("R1 R4 after first fetch", ctrl, 16'h0000);
  endtask

  task automatic t_seq(input logic [7:0] op);
    go_idle(op);
    for (int i = 0; i <= int'(op[1:0]); i++) begin
      tick();
      chk("R5 R3 ctrl", ctrl, exp_word(op, 4'(i)));
      chk("R5 q", {12'h0, rom_addr[3:0]}, 16'(i + 1));
    end
    tick();
    chk("R4 R6 end ctrl", ctrl, 16'h0000);
    chk("R6 q zero", {12'h0, rom_addr[3:0]}, 16'h0);
  endtask

  task automatic t_addr();
    go_idle(8'h43);
    tick();
    opcode = 8'h97;
    #1;
    chk("R2 addr", {4'h0, rom_addr}, {4'h0, 8'h97, 4'h1});
    opcode = 8'h43;
    #1;
  endtask

  task automatic t_force();
    go_idle(8'h43);
    tick();
    force_fetch = 1'b1; inj_valid = 1'b1; inj_word = 16'hA5C4; stall = 1'b1;
    tick();
    force_fetch = 1'b0; inj_valid = 1'b0; stall = 1'b0;
    chk("R7 R10 forced word", ctrl, 16'h0003);
    chk("R7 q", {12'h0, rom_addr[3:0]}, 16'h0);
    tick();
    chk("R7 cleared after", ctrl, 16'h0000);
  endtask

  task automatic t_stall();
    go_idle(8'h43);
    tick();
    stall = 1'b1;
    tick();
    stall = 1'b0;
    chk("R8 ctrl", ctrl, exp_word(8'h43, 4'd1));
    chk("R8 q held", {12'h0, rom_addr[3:0]}, 16'h1);
    tick();
    chk("R8 reload same word", ctrl, exp_word(8'h43, 4'd1));
    chk("R8 q resumes", {12'h0, rom_addr[3:0]}, 16'h2);
  endtask

  task automatic t_inject_stall();
    go_idle(8'h43);
    tick();
    stall = 1'b1; inj_valid = 1'b1; inj_word = 16'hA5C4;
    tick();
    stall = 1'b0; inj_valid = 1'b0;
    chk("R9 injected", ctrl, 16'hA5C4);
    chk("R8 R9 q held", {12'h0, rom_addr[3:0]}, 16'h1);
    tick();
    chk("R9 resume", ctrl, exp_word(8'h43, 4'd1));
  endtask

  task automatic t_inject_end();
    go_idle(8'h43);
    tick();
    inj_valid = 1'b1; inj_word = 16'h0002;
    tick();
    inj_valid = 1'b0;
    chk("R9 injected end", ctrl, 16'h0002);
    chk("R9 q advanced", {12'h0, rom_addr[3:0]}, 16'h2);
    tick();
    chk("R6 word after end", ctrl, exp_word(8'h43, 4'd2));
    chk("R6 q zero", {12'h0, rom_addr[3:0]}, 16'h0);
  endtask

  task automatic t_fetch_priority();
    go_idle(8'h43);
    tick();
    op_fetch = 1'b1; inj_valid = 1'b1; inj_word = 16'h5A50;
    tick();
    op_fetch = 1'b0; inj_valid = 1'b0;
    chk("R10 R4 clear wins", ctrl, 16'h0000);
    chk("R10 q", {12'h0, rom_addr[3:0]}, 16'h0);
  endtask

  task automatic t_reset_mid();
    go_idle(8'h43);
    tick();
    rst_n = 1'b0;
    tick();
    chk("R1 mid reset ctrl", ctrl, 16'h0003);
    chk("R1 mid reset q", {12'h0, rom_addr[3:0]}, 16'h0);
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    rst_n = 1'b0; op_fetch = 1'b0; force_fetch = 1'b0; stall = 1'b0;
    inj_valid = 1'b0; inj_word = 16'h0; opcode = 8'h00;
    t_reset();
    t_seq(8'h42);
    t_seq(8'h10);
    t_seq(8'hC7);
    t_seq(8'h35);
    t_addr();
    t_force();
    t_stall();
    t_inject_stall();
    t_inject_end();
    t_fetch_priority();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule